// File: doc/BRIEF.md
# String Transfer Engine with Repeat

This block is a small sequencer that carries out one string primitive per start pulse. It works on byte or word elements and supports five operations: load into the accumulator, store from the accumulator, memory-to-memory move, compare of two strings, and scan of a string against the accumulator. It reaches memory through a simple request/ready port. The surrounding core supplies the working registers at start: the source index, the destination index, the count, the accumulator, the direction flag and the incoming flags. The engine holds and updates its own copies, and presents them on its outputs once the instruction has finished.

A repeat prefix turns one start into a loop over the count. Three repeat forms are supported. The first runs until the count is exhausted. The second stops early once an element compares unequal. The third stops early once an element compares equal. Physical addresses are formed from a segment value and a 16-bit offset. A done pulse marks the end of each instruction.

Top module: `strx_engine`

## Requirements
- R1: Each access address is (segment << 4) + offset, truncated to 20 bits. The source side uses the data segment and the source index. The destination side uses the extra segment and the destination index. `mem_wide_o` is 1 for word elements and 0 for byte elements.
- R2: After each element, each pointer the operation uses moves by 1 (byte) or 2 (word). It moves up when the direction flag is 0 and down when it is 1, wrapping at 16 bits.
- R3: Load (op 0) reads the source element. A byte replaces only the low accumulator byte, and the upper byte is kept. A word replaces the whole accumulator. Only the source index steps.
- R4: Store (op 1) writes the accumulator to the destination, with only the low byte valid for byte elements. Only the destination index steps.
- R5: Move (op 2) reads the source element, then writes it to the destination. Both indices step.
- R6: Compare (op 3) forms source minus destination and sets ZF (result zero), CF (borrow) and SF (result MSB). It never writes memory, and both indices step.
- R7: Scan (op 4) forms accumulator minus destination element, sets the same flags, and steps only the destination index. The upper accumulator byte is ignored for byte elements.
- R8: With repeat mode 1, the element is repeated until the count reaches 0. The count drops by exactly 1 per element.
- R9: Repeat mode 2 continues only while the count is nonzero and ZF is 1. Repeat mode 3 continues only while the count is nonzero and ZF is 0. The test is made after each element's count decrement.
- R10: A repeated instruction (mode 1, 2 or 3) that starts with a count of 0 makes no memory access. It asserts done in the first cycle after the start edge and leaves all registers unchanged.
- R11: With repeat mode 0, exactly one element is processed and the count is left unchanged.
- R12: A request is held with stable address, write enable and write data until ready is seen. Done is a one-cycle pulse. A start that arrives while the engine is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch one instruction when idle |
| op_i | input | 3 | Operation: 0 load, 1 store, 2 move, 3 compare, 4 scan |
| rep_i | input | 2 | Repeat mode: 0 none, 1 count, 2 while equal, 3 while not equal |
| word_i | input | 1 | 1 = word elements, 0 = byte elements |
| df_i | input | 1 | Direction flag |
| ds_i | input | 16 | Source segment |
| es_i | input | 16 | Destination segment |
| si_i | input | 16 | Initial source index |
| di_i | input | 16 | Initial destination index |
| cx_i | input | 16 | Initial count |
| ax_i | input | 16 | Initial accumulator |
| zf_i | input | 1 | Initial zero flag |
| cf_i | input | 1 | Initial carry flag |
| sf_i | input | 1 | Initial sign flag |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle end-of-instruction pulse |
| si_o | output | 16 | Current source index |
| di_o | output | 16 | Current destination index |
| cx_o | output | 16 | Current count |
| ax_o | output | 16 | Current accumulator |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry (borrow) flag |
| sf_o | output | 1 | Sign flag |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write enable |
| mem_wide_o | output | 1 | Word access when 1 |
| mem_addr_o | output | 20 | Physical address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access complete |

## Verification
A repeated instruction with a zero count must raise done in the very first cycle after the start edge. Any other instruction finishes one pointer-step cycle after the ready of its last access, and raises done in the cycle after that. For one byte load with no wait states, this puts done three cycles after the start edge. The bench drives inputs and samples outputs on falling edges, and counts the falling edges from start to done. It checks that count exactly in the zero-count and no-wait cases. All register, flag and memory results are read at the falling edge where done is first seen, which is the cycle in which the final values must already be present.

// File: rtl/strx_pkg.sv
// Package: shared types and helpers for the string transfer engine.
// Assumes op and repeat encodings are fixed by the block's port contract.
package strx_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_MOVE  = 3'd2,
        OP_CMP   = 3'd3,
        OP_SCAN  = 3'd4
    } str_op_e;

    typedef enum logic [1:0] {
        RP_NONE = 2'd0,
        RP_ALL  = 2'd1,
        RP_EQ   = 2'd2,
        RP_NE   = 2'd3
    } rep_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SRC_RD = 3'd1,
        ST_DST_RD = 3'd2,
        ST_DST_WR = 3'd3,
        ST_STEP   = 3'd4,
        ST_DONE   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic zf;
        logic cf;
        logic sf;
    } flags_t;

    // First access state of an element for a given operation
    function automatic seq_state_e entry_state(str_op_e op);
        case (op)
            OP_LOAD, OP_MOVE, OP_CMP: return ST_SRC_RD;
            OP_STORE:                 return ST_DST_WR;
            OP_SCAN:                  return ST_DST_RD;
            default:                  return ST_DONE;
        endcase
    endfunction

    // Operation consumes the source pointer
    function automatic logic uses_src(str_op_e op);
        return (op == OP_LOAD) || (op == OP_MOVE) || (op == OP_CMP);
    endfunction

    // Operation consumes the destination pointer
    function automatic logic uses_dst(str_op_e op);
        return (op == OP_STORE) || (op == OP_MOVE) || (op == OP_CMP) || (op == OP_SCAN);
    endfunction

endpackage

// File: rtl/strx_agen.sv
// Module: physical address generator.
// Forms (segment << SHIFT) + offset and truncates to PADDR_W bits.
// Assumes PADDR_W covers the shifted segment width of interest; higher bits wrap.
module strx_agen #(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int PADDR_W = 20
) (
    input  logic [SEG_W-1:0]   seg_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [PADDR_W-1:0] paddr_o
);

    // Wrapping address sum in the physical width
    always_comb begin
        paddr_o = (PADDR_W'(seg_i) << SHIFT) + PADDR_W'(off_i);
    end

endmodule

// File: rtl/strx_ptrstep.sv
// Module: pointer stepper.
// Returns the pointer moved by one element (1 byte or 2 bytes).
// The direction flag selects decrement. Wraps at OFF_W bits.
module strx_ptrstep #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] ptr_i,
    input  logic             word_i,
    input  logic             df_i,
    output logic [OFF_W-1:0] ptr_o
);

    localparam logic [OFF_W-1:0] STEP_B = OFF_W'(1);
    localparam logic [OFF_W-1:0] STEP_W = OFF_W'(2);

    logic [OFF_W-1:0] step;

    // Select element size and apply direction
    always_comb begin
        step  = word_i ? STEP_W : STEP_B;
        ptr_o = df_i ? (ptr_i - step) : (ptr_i + step);
    end

endmodule

// File: rtl/strx_cmp.sv
// Module: element subtractor for compare and scan.
// Computes a - b on the low half (byte) or the full width (word).
// Produces zero, borrow and sign flags; the result itself is discarded.
module strx_cmp
    import strx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              word_i,
    output flags_t            flags_o
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] diff_w;
    logic [HALF_W:0] diff_b;

    // Width-selected subtraction with borrow out
    always_comb begin
        diff_w = {1'b0, a_i} - {1'b0, b_i};
        diff_b = {1'b0, a_i[HALF_W-1:0]} - {1'b0, b_i[HALF_W-1:0]};
        if (word_i) begin
            flags_o.zf = (diff_w[DATA_W-1:0] == '0);
            flags_o.cf = diff_w[DATA_W];
            flags_o.sf = diff_w[DATA_W-1];
        end else begin
            flags_o.zf = (diff_b[HALF_W-1:0] == '0);
            flags_o.cf = diff_b[HALF_W];
            flags_o.sf = diff_b[HALF_W-1];
        end
    end

endmodule

// File: rtl/strx_engine.sv
// Module: string transfer engine with repeat (top).
// Runs one load/store/move/compare/scan instruction per start pulse,
// optionally repeated under a count and a zero-flag condition.
// Assumes: single outstanding memory access, ready is a one-cycle completion
// strobe, a word is one access at the element address, and byte read data
// sits in the low byte. Segments and registers are captured at start.
module strx_engine
    import strx_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_W     = 16,
    parameter int CNT_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int PADDR_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [2:0]         op_i,
    input  logic [1:0]         rep_i,
    input  logic               word_i,
    input  logic               df_i,
    input  logic [SEG_W-1:0]   ds_i,
    input  logic [SEG_W-1:0]   es_i,
    input  logic [OFF_W-1:0]   si_i,
    input  logic [OFF_W-1:0]   di_i,
    input  logic [CNT_W-1:0]   cx_i,
    input  logic [DATA_W-1:0]  ax_i,
    input  logic               zf_i,
    input  logic               cf_i,
    input  logic               sf_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [OFF_W-1:0]   si_o,
    output logic [OFF_W-1:0]   di_o,
    output logic [CNT_W-1:0]   cx_o,
    output logic [DATA_W-1:0]  ax_o,
    output logic               zf_o,
    output logic               cf_o,
    output logic               sf_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic               mem_wide_o,
    output logic [PADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0]  mem_wdata_o,
    input  logic [DATA_W-1:0]  mem_rdata_i,
    input  logic               mem_rdy_i
);

    localparam int HALF_W = DATA_W / 2;
    localparam int NPTR   = 2;   // index 0: source side, index 1: destination side

    seq_state_e        state_q;
    str_op_e           op_q;
    rep_mode_e         rep_q;
    logic              word_q;
    logic              df_q;
    logic [SEG_W-1:0]  ds_q;
    logic [SEG_W-1:0]  es_q;
    logic [OFF_W-1:0]  si_q;
    logic [OFF_W-1:0]  di_q;
    logic [CNT_W-1:0]  cx_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] tmp_q;
    flags_t            flags_q;

    logic [SEG_W-1:0]   seg_sel  [NPTR];
    logic [OFF_W-1:0]   ptr_cur  [NPTR];
    logic [OFF_W-1:0]   ptr_nxt  [NPTR];
    logic [PADDR_W-1:0] paddr    [NPTR];

    logic [DATA_W-1:0] rd_eff;
    logic [DATA_W-1:0] cmp_a;
    logic [DATA_W-1:0] wr_val;
    flags_t            cmp_flags;
    logic [CNT_W-1:0]  cx_dec;
    logic              more;

    assign seg_sel[0] = ds_q;
    assign seg_sel[1] = es_q;
    assign ptr_cur[0] = si_q;
    assign ptr_cur[1] = di_q;

    // One address generator and one stepper per pointer side
    for (genvar g = 0; g < NPTR; g++) begin : g_side
        strx_agen #(
            .SEG_W  (SEG_W),
            .OFF_W  (OFF_W),
            .SHIFT  (SEG_SHIFT),
            .PADDR_W(PADDR_W)
        ) u_agen (
            .seg_i  (seg_sel[g]),
            .off_i  (ptr_cur[g]),
            .paddr_o(paddr[g])
        );

        strx_ptrstep #(
            .OFF_W(OFF_W)
        ) u_step (
            .ptr_i (ptr_cur[g]),
            .word_i(word_q),
            .df_i  (df_q),
            .ptr_o (ptr_nxt[g])
        );
    end

    // Read data masked to element width
    always_comb begin
        rd_eff = word_q ? mem_rdata_i : {{HALF_W{1'b0}}, mem_rdata_i[HALF_W-1:0]};
    end

    // Minuend: latched source element for compare, accumulator for scan
    always_comb begin
        cmp_a = (op_q == OP_CMP) ? tmp_q : acc_q;
    end

    strx_cmp #(
        .DATA_W(DATA_W)
    ) u_cmp (
        .a_i    (cmp_a),
        .b_i    (rd_eff),
        .word_i (word_q),
        .flags_o(cmp_flags)
    );

    // Repeat continuation decision taken in the step cycle
    always_comb begin
        cx_dec = cx_q - CNT_W'(1);
        case (rep_q)
            RP_ALL:  more = (cx_dec != '0);
            RP_EQ:   more = (cx_dec != '0) && flags_q.zf;
            RP_NE:   more = (cx_dec != '0) && !flags_q.zf;
            default: more = 1'b0;
        endcase
    end

    // Memory port drive from the current state
    always_comb begin
        wr_val      = (op_q == OP_MOVE) ? tmp_q : acc_q;
        mem_req_o   = (state_q == ST_SRC_RD) || (state_q == ST_DST_RD) || (state_q == ST_DST_WR);
        mem_we_o    = (state_q == ST_DST_WR);
        mem_wide_o  = word_q;
        mem_addr_o  = (state_q == ST_SRC_RD) ? paddr[0] : paddr[1];
        mem_wdata_o = word_q ? wr_val : {{HALF_W{1'b0}}, wr_val[HALF_W-1:0]};
    end

    // Sequencer and architectural register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_LOAD;
            rep_q   <= RP_NONE;
            word_q  <= 1'b0;
            df_q    <= 1'b0;
            ds_q    <= '0;
            es_q    <= '0;
            si_q    <= '0;
            di_q    <= '0;
            cx_q    <= '0;
            acc_q   <= '0;
            tmp_q   <= '0;
            flags_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        op_q       <= str_op_e'(op_i);
                        rep_q      <= rep_mode_e'(rep_i);
                        word_q     <= word_i;
                        df_q       <= df_i;
                        ds_q       <= ds_i;
                        es_q       <= es_i;
                        si_q       <= si_i;
                        di_q       <= di_i;
                        cx_q       <= cx_i;
                        acc_q      <= ax_i;
                        flags_q.zf <= zf_i;
                        flags_q.cf <= cf_i;
                        flags_q.sf <= sf_i;
                        if ((rep_mode_e'(rep_i) != RP_NONE) && (cx_i == '0)) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= entry_state(str_op_e'(op_i));
                        end
                    end
                end
                ST_SRC_RD: begin
                    if (mem_rdy_i) begin
                        case (op_q)
                            OP_LOAD: begin
                                acc_q   <= word_q ? mem_rdata_i
                                                  : {acc_q[DATA_W-1:HALF_W], mem_rdata_i[HALF_W-1:0]};
                                state_q <= ST_STEP;
                            end
                            OP_MOVE: begin
                                tmp_q   <= rd_eff;
                                state_q <= ST_DST_WR;
                            end
                            default: begin
                                tmp_q   <= rd_eff;
                                state_q <= ST_DST_RD;
                            end
                        endcase
                    end
                end
                ST_DST_RD: begin
                    if (mem_rdy_i) begin
                        flags_q <= cmp_flags;
                        state_q <= ST_STEP;
                    end
                end
                ST_DST_WR: begin
                    if (mem_rdy_i) begin
                        state_q <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (uses_src(op_q)) begin
                        si_q <= ptr_nxt[0];
                    end
                    if (uses_dst(op_q)) begin
                        di_q <= ptr_nxt[1];
                    end
                    if (rep_q != RP_NONE) begin
                        cx_q <= cx_dec;
                    end
                    state_q <= more ? entry_state(op_q) : ST_DONE;
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Architectural outputs
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_DONE);
        si_o   = si_q;
        di_o   = di_q;
        cx_o   = cx_q;
        ax_o   = acc_q;
        zf_o   = flags_q.zf;
        cf_o   = flags_q.cf;
        sf_o   = flags_q.sf;
    end

endmodule

// File: rtl/strx_engine_chk.sv
// Module: protocol and sequencing checker for the string transfer engine.
// Bound to every strx_engine instance; observes ports and latched op/repeat.
module strx_engine_chk
    import strx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int OFF_W   = 16,
    parameter int CNT_W   = 16,
    parameter int PADDR_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [1:0]         rep_i,
    input logic [CNT_W-1:0]   cx_i,
    input logic               busy_o,
    input logic               done_o,
    input logic               mem_req_o,
    input logic               mem_we_o,
    input logic               mem_rdy_i,
    input logic [PADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0]  mem_wdata_o,
    input logic [CNT_W-1:0]   cx_o,
    input logic [OFF_W-1:0]   si_o,
    input logic [OFF_W-1:0]   di_o,
    input str_op_e            op_q,
    input rep_mode_e          rep_q
);

    // R12: pending request keeps its address, direction and data
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R12: done lasts exactly one cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: repeated start with zero count finishes at once with no access
    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (rep_i != 2'd0) && (cx_i == '0)) |=> (done_o && !mem_req_o));

    // R8: the count only ever drops by one while an instruction runs
    p_cx_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ((cx_o == $past(cx_o)) || (cx_o == $past(cx_o) - CNT_W'(1))));

    // R11: without repeat the count is frozen
    p_norep_cx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (rep_q == RP_NONE)) |-> $stable(cx_o));

    // R6: load, compare and scan never write memory (R7, R3 as well)
    p_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && ((op_q == OP_LOAD) || (op_q == OP_CMP) || (op_q == OP_SCAN))) |-> !mem_we_o);

    // R2: source index moves by one element size only
    p_si_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (si_o != $past(si_o))) |->
            (((si_o - $past(si_o)) == OFF_W'(1)) || ((si_o - $past(si_o)) == OFF_W'(2)) ||
             (($past(si_o) - si_o) == OFF_W'(1)) || (($past(si_o) - si_o) == OFF_W'(2))));

    // R2: destination index moves by one element size only
    p_di_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && (di_o != $past(di_o))) |->
            (((di_o - $past(di_o)) == OFF_W'(1)) || ((di_o - $past(di_o)) == OFF_W'(2)) ||
             (($past(di_o) - di_o) == OFF_W'(1)) || (($past(di_o) - di_o) == OFF_W'(2))));

endmodule

bind strx_engine strx_engine_chk #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W),
    .PADDR_W(PADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rep_i      (rep_i),
    .cx_i       (cx_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_rdy_i  (mem_rdy_i),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .cx_o       (cx_o),
    .si_o       (si_o),
    .di_o       (di_o),
    .op_q       (op_q),
    .rep_q      (rep_q)
);

// File: tb/tb_strx_engine.sv
`timescale 1ns/1ps
// Directed bench for strx_engine: one task per scenario, each checking itself.
module tb_strx_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  rep_i = '0;
    logic        word_i = 1'b0;
    logic        df_i = 1'b0;
    logic [15:0] ds_i = '0, es_i = '0, si_i = '0, di_i = '0, cx_i = '0, ax_i = '0;
    logic        zf_i = 1'b0, cf_i = 1'b0, sf_i = 1'b0;
    logic        busy_o, done_o, zf_o, cf_o, sf_o;
    logic [15:0] si_o, di_o, cx_o, ax_o;
    logic        mem_req_o, mem_we_o, mem_wide_o;
    logic [19:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;
    logic        mem_rdy_i = 1'b0;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned wait_cyc = 0;
    int unsigned wcnt = 0;
    int unsigned acc_cnt = 0;
    int unsigned base_cnt = 0;
    int unsigned last_lat = 0;
    logic [7:0]  bm [0:4095];
    logic [19:0] alog [0:63];
    logic        wlog [0:63];

    always #2.5 clk = ~clk;

    strx_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .rep_i(rep_i),
        .word_i(word_i), .df_i(df_i), .ds_i(ds_i), .es_i(es_i), .si_i(si_i),
        .di_i(di_i), .cx_i(cx_i), .ax_i(ax_i), .zf_i(zf_i), .cf_i(cf_i), .sf_i(sf_i),
        .busy_o(busy_o), .done_o(done_o), .si_o(si_o), .di_o(di_o), .cx_o(cx_o),
        .ax_o(ax_o), .zf_o(zf_o), .cf_o(cf_o), .sf_o(sf_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_wide_o(mem_wide_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
    );

    // Byte-addressed memory model with programmable wait states
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rdy_i <= 1'b0;
            wcnt      <= 0;
            acc_cnt   <= 0;
        end else if (mem_req_o && !mem_rdy_i) begin
            if (wcnt >= wait_cyc) begin
                mem_rdy_i   <= 1'b1;
                wcnt        <= 0;
                mem_rdata_i <= {bm[mem_addr_o[11:0] + 12'd1], bm[mem_addr_o[11:0]]};
                if (mem_we_o) begin
                    bm[mem_addr_o[11:0]] = mem_wdata_o[7:0];
                    if (mem_wide_o) bm[mem_addr_o[11:0] + 12'd1] = mem_wdata_o[15:8];
                end
                if (acc_cnt < 64) begin
                    alog[acc_cnt] <= mem_addr_o;
                    wlog[acc_cnt] <= mem_wide_o;
                end
                acc_cnt <= acc_cnt + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_rdy_i <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] v);
        bm[a[11:0]] = v;
    endtask

    // Launch one instruction and wait for done; records latency in falling edges
    task automatic run_op(input logic [2:0] op, input logic [1:0] rep, input logic wd,
                          input logic df, input logic [15:0] ds, input logic [15:0] es,
                          input logic [15:0] si, input logic [15:0] di,
                          input logic [15:0] cx, input logic [15:0] ax, input logic zf);
        int unsigned n;
        @(negedge clk);
        base_cnt = acc_cnt;
        op_i = op; rep_i = rep; word_i = wd; df_i = df; ds_i = ds; es_i = es;
        si_i = si; di_i = di; cx_i = cx; ax_i = ax; zf_i = zf; cf_i = 1'b0; sf_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk("R12 done timeout", 32'(n), 0);
        last_lat = n;
    endtask

    task automatic t_reset;
        chk("R12 reset busy", 32'(busy_o), 0);
        chk("R12 reset done", 32'(done_o), 0);
        chk("R12 reset req", 32'(mem_req_o), 0);
        chk("R8 reset count", 32'(cx_o), 0);
    endtask

    task automatic t_load_byte;
        wait_cyc = 0;
        poke(12'h350, 8'h5A); poke(12'h351, 8'hC3);
        run_op(3'd0, 2'd0, 1'b0, 1'b0, 16'h1234, 16'h0000, 16'h0010, 16'h4444, 16'd9, 16'h7700, 1'b0);
        chk("R1 load byte address", 32'(alog[base_cnt]), 32'h12350);
        chk("R1 load byte width", 32'(wlog[base_cnt]), 0);
        chk("R3 load byte keeps high byte", 32'(ax_o), 32'h775A);
        chk("R3 load byte SI step", 32'(si_o), 32'h0011);
        chk("R3 load byte DI unchanged", 32'(di_o), 32'h4444);
        chk("R11 single element count kept", 32'(cx_o), 9);
        chk("R11 single access", acc_cnt - base_cnt, 1);
        chk("R12 no-wait done latency", 32'(last_lat), 3);
    endtask

    task automatic t_load_word_wrap;
        wait_cyc = 1;
        poke(12'h010, 8'h34); poke(12'h011, 8'h12);
        run_op(3'd0, 2'd0, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 16'h0020, 16'h0000, 16'd0, 16'h0000, 1'b0);
        chk("R1 address wraps to 20 bits", 32'(alog[base_cnt]), 32'h00010);
        chk("R1 load word width", 32'(wlog[base_cnt]), 1);
        chk("R3 load word value", 32'(ax_o), 32'h1234);
        chk("R2 word step down", 32'(si_o), 32'h001E);
    endtask

    task automatic t_store_rep;
        wait_cyc = 0;
        for (int i = 0; i < 4; i++) poke(12'h205 + i, 8'h00);
        run_op(3'd1, 2'd1, 1'b0, 1'b0, 16'h0000, 16'h0020, 16'h3333, 16'h0005, 16'd3, 16'h99AB, 1'b0);
        for (int i = 0; i < 3; i++) chk("R4 stored byte", 32'(bm[12'h205 + i]), 32'hAB);
        chk("R8 store stops at count", 32'(bm[12'h208]), 0);
        chk("R8 count reaches zero", 32'(cx_o), 0);
        chk("R8 store access count", acc_cnt - base_cnt, 3);
        chk("R4 DI advanced", 32'(di_o), 32'h0008);
        chk("R4 SI untouched", 32'(si_o), 32'h3333);
        chk("R2 second address", 32'(alog[base_cnt + 1]), 32'h00206);
    endtask

    task automatic t_move_rep;
        wait_cyc = 2;
        for (int i = 0; i < 8; i++) begin
            poke(12'h300 + i, 8'h10 + 8'(i));
            poke(12'h410 + i, 8'h00);
        end
        run_op(3'd2, 2'd1, 1'b1, 1'b1, 16'h0030, 16'h0040, 16'h0006, 16'h0016, 16'd4, 16'h0000, 1'b0);
        for (int i = 0; i < 8; i++) chk("R5 moved byte", 32'(bm[12'h410 + i]), 32'h10 + i);
        chk("R5 SI down with wrap", 32'(si_o), 32'hFFFE);
        chk("R5 DI down", 32'(di_o), 32'h000E);
        chk("R5 access count", acc_cnt - base_cnt, 8);
        chk("R5 first read address", 32'(alog[base_cnt]), 32'h00306);
        chk("R5 first write address", 32'(alog[base_cnt + 1]), 32'h00416);
    endtask

    task automatic t_cmp_repe;
        wait_cyc = 0;
        poke(12'h500, 8'h41); poke(12'h501, 8'h42); poke(12'h502, 8'h43); poke(12'h503, 8'h58);
        poke(12'h600, 8'h41); poke(12'h601, 8'h42); poke(12'h602, 8'h43); poke(12'h603, 8'h59);
        run_op(3'd3, 2'd2, 1'b0, 1'b0, 16'h0050, 16'h0060, 16'h0000, 16'h0000, 16'd10, 16'h0000, 1'b1);
        chk("R9 while-equal stops at mismatch", 32'(cx_o), 6);
        chk("R6 ZF clear", 32'(zf_o), 0);
        chk("R6 CF borrow", 32'(cf_o), 1);
        chk("R6 SF set", 32'(sf_o), 1);
        chk("R6 SI step", 32'(si_o), 4);
        chk("R6 DI step", 32'(di_o), 4);
        chk("R6 no write to destination", 32'(bm[12'h603]), 32'h59);
    endtask

    task automatic t_scan_repne;
        wait_cyc = 1;
        poke(12'h700, 8'h01); poke(12'h701, 8'h00);
        poke(12'h702, 8'h02); poke(12'h703, 8'h00);
        poke(12'h704, 8'hEF); poke(12'h705, 8'hBE);
        poke(12'h706, 8'h04); poke(12'h707, 8'h00);
        run_op(3'd4, 2'd3, 1'b1, 1'b0, 16'h0000, 16'h0070, 16'h1111, 16'h0000, 16'd8, 16'hBEEF, 1'b0);
        chk("R9 while-not-equal stops at match", 32'(cx_o), 5);
        chk("R7 ZF set", 32'(zf_o), 1);
        chk("R7 CF clear", 32'(cf_o), 0);
        chk("R7 DI step", 32'(di_o), 6);
        chk("R7 SI untouched", 32'(si_o), 32'h1111);
        chk("R7 accesses", acc_cnt - base_cnt, 3);
    endtask

    task automatic t_scan_byte_single;
        wait_cyc = 0;
        poke(12'h720, 8'h20);
        run_op(3'd4, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h0072, 16'h0000, 16'h0000, 16'd5, 16'hFF10, 1'b1);
        chk("R7 byte scan ZF", 32'(zf_o), 0);
        chk("R7 byte scan CF", 32'(cf_o), 1);
        chk("R7 byte scan SF", 32'(sf_o), 1);
        chk("R11 count unchanged", 32'(cx_o), 5);
        chk("R11 DI one step", 32'(di_o), 1);
    endtask

    task automatic t_cmp_repne_exhaust;
        wait_cyc = 0;
        poke(12'h510, 8'h00); poke(12'h511, 8'h10); poke(12'h512, 8'h00); poke(12'h513, 8'h20);
        poke(12'h610, 8'hFF); poke(12'h611, 8'h0F); poke(12'h612, 8'h00); poke(12'h613, 8'h30);
        run_op(3'd3, 2'd3, 1'b1, 1'b0, 16'h0051, 16'h0061, 16'h0000, 16'h0000, 16'd2, 16'h0000, 1'b1);
        chk("R9 ends on count", 32'(cx_o), 0);
        chk("R6 word ZF", 32'(zf_o), 0);
        chk("R6 word CF", 32'(cf_o), 1);
        chk("R6 word SF", 32'(sf_o), 1);
        chk("R6 word SI", 32'(si_o), 4);
    endtask

    task automatic t_zero_count;
        wait_cyc = 0;
        run_op(3'd2, 2'd1, 1'b1, 1'b0, 16'h0030, 16'h0040, 16'h0123, 16'h0456, 16'd0, 16'hAAAA, 1'b0);
        chk("R10 done in first cycle", 32'(last_lat), 0);
        chk("R10 no memory access", acc_cnt - base_cnt, 0);
        chk("R10 SI unchanged", 32'(si_o), 32'h0123);
        chk("R10 DI unchanged", 32'(di_o), 32'h0456);
        chk("R10 count stays zero", 32'(cx_o), 0);
    endtask

    task automatic t_store_word_wrap;
        wait_cyc = 0;
        run_op(3'd1, 2'd0, 1'b1, 1'b0, 16'h0000, 16'h0080, 16'h0000, 16'hFFFF, 16'd1, 16'hCAFE, 1'b0);
        chk("R1 store address", 32'(alog[base_cnt]), 32'h107FF);
        chk("R4 store low byte", 32'(bm[12'h7FF]), 32'hFE);
        chk("R4 store high byte", 32'(bm[12'h800]), 32'hCA);
        chk("R2 DI wraps up", 32'(di_o), 32'h0001);
    endtask

    task automatic t_start_while_busy;
        wait_cyc = 3;
        poke(12'h900, 8'h66);
        poke(12'hA00, 8'h11);
        @(negedge clk);
        base_cnt = acc_cnt;
        op_i = 3'd0; rep_i = 2'd0; word_i = 1'b0; df_i = 1'b0;
        ds_i = 16'h0090; es_i = 16'h00A0; si_i = 16'h0000; di_i = 16'h0000;
        cx_i = 16'd1; ax_i = 16'h1200;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        op_i = 3'd1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 0; n < 100 && !done_o; n++) @(negedge clk);
        chk("R12 first op completes", 32'(ax_o), 32'h1266);
        chk("R12 busy start ignored", acc_cnt - base_cnt, 1);
        chk("R12 no stray write", 32'(bm[12'hA00]), 32'h11);
        @(negedge clk);
        chk("R12 done one cycle", 32'(done_o), 0);
        chk("R12 back to idle", 32'(busy_o), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_byte();
        t_load_word_wrap();
        t_store_rep();
        t_move_rep();
        t_cmp_repe();
        t_scan_repne();
        t_scan_byte_single();
        t_cmp_repne_exhaust();
        t_zero_count();
        t_store_word_wrap();
        t_start_while_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule